// File: doc/BRIEF.md
# I2C Slave Status Flag Controller

This block keeps the status byte of an I2C slave port. A separate bit engine
does the shifting, address comparison and start/stop detection. It reports
each finished event to this block as a one-cycle strobe. The controller turns
those strobes into sticky flags and latched fields. It derives a clock-stretch
request from the flags that are pending. It also gates the engine's request to
pull SDA low while a transmit collision is outstanding.

Software sees the flags through a single packed status byte. It clears them in
two ways. It can write a 1 to the flag's bit. More often, a flag clears as a
side effect of touching the data register or issuing a valid command. Two
interrupt requests come out of the two transfer flags, each gated by its own
enable.

Top module: `i2cs_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and all outputs are low. The byte is packed as follows: bit 7 = data flag, bit 6 = address/stop flag, bit 5 = clock hold, bit 4 = received ack, bit 3 = collision, bit 2 = bus error, bit 1 = direction, bit 0 = address-or-stop cause.
- R2: A byte-complete strobe sets the data flag on the next cycle. This also happens when a collision is pending.
- R3: A data-register read, a data-register write or a valid command write clears both the data flag and the address/stop flag on the next cycle.
- R4: An address-match strobe or a stop strobe sets the address/stop flag. Bit 0 becomes 1 for an address and 0 for a stop. If both arrive together, the address wins.
- R5: A register write clears bits 7, 6, 3 and 2 wherever its data bit is 1. Write data on bits 5, 4, 1 and 0 has no effect.
- R6: Bit 5 and the clock-stretch output are 1 exactly while the data flag or the address/stop flag is set.
- R7: Bit 4 takes the sampled acknowledge value on each acknowledge strobe: 0 for ACK, 1 for NACK. Between strobes it holds.
- R8: A collision strobe sets bit 3. While bit 3 is set, the SDA drive-low output stays 0 whatever the engine requests. The bit clears on a start/repeated-start strobe, or on a write of 1 to it.
- R9: An illegal-condition strobe sets bit 2 only while the master-enable input is high.
- R10: An address-match strobe latches the received read/write bit into bit 1 (1 = master read, 0 = master write). Bit 1 holds until the next address match.
- R11: The data interrupt is the data flag ANDed with its enable. The address interrupt is the address/stop flag ANDed with its enable.
- R12: When a set and a clear reach the same flag in one cycle, the flag ends up set.
- R13: A status read strobe on its own changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_byte_done | input | 1 | Byte transfer finished |
| ev_addr_match | input | 1 | Own address recognised |
| ev_stop | input | 1 | Stop condition seen |
| ev_start | input | 1 | Start or repeated start seen |
| ev_ack_valid | input | 1 | Acknowledge bit sampled this cycle |
| ack_bit | input | 1 | Sampled acknowledge value (1 = NACK) |
| addr_dir | input | 1 | Read/write bit of the received address |
| ev_coll | input | 1 | Transmit collision detected |
| ev_illegal | input | 1 | Protocol-violating start/stop detected |
| master_en | input | 1 | Master side enabled; qualifies bus-error detection |
| eng_sda_low | input | 1 | Engine requests SDA pulled low |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| cmd_wr | input | 1 | Valid command written |
| dif_ien | input | 1 | Data interrupt enable |
| aif_ien | input | 1 | Address/stop interrupt enable |
| status | output | 8 | Packed status byte |
| scl_hold | output | 1 | Clock-stretch request |
| sda_drive_low | output | 1 | Gated SDA pull-low request |
| irq_data | output | 1 | Data interrupt request |
| irq_addr | output | 1 | Address/stop interrupt request |

## Verification
Every flag and latched field is one register deep. A strobe or register access
therefore shows in the status byte one clock edge after the cycle that carries
it. The clock-stretch request and both interrupts are combinational from those
registers, so they follow the status byte in the same cycle. The SDA gate is
combinational from the collision flag and from the live engine request. The
bench drives inputs on the falling edge and compares every output against its
own model at the next falling edge. That point lies after exactly one rising
edge, which matches the one-register latency.

// File: rtl/i2cs_stat_pkg.sv
package i2cs_stat_pkg;
   localparam int STAT_W  = 8;
   // status byte bit positions
   localparam int B_DIF   = 7;
   localparam int B_APIF  = 6;
   localparam int B_HOLD  = 5;
   localparam int B_RXACK = 4;
   localparam int B_COLL  = 3;
   localparam int B_BERR  = 2;
   localparam int B_DIR   = 1;
   localparam int B_AP    = 0;
   // sticky write-one-to-clear flag slots
   localparam int N_STICKY = 4;
   localparam int I_DIF  = 0;
   localparam int I_APIF = 1;
   localparam int I_COLL = 2;
   localparam int I_BERR = 3;

   function automatic int sticky_pos(input int idx);
      case (idx)
         I_DIF:   return B_DIF;
         I_APIF:  return B_APIF;
         I_COLL:  return B_COLL;
         default: return B_BERR;
      endcase
   endfunction
endpackage

// File: rtl/i2cs_flag_cell.sv
module i2cs_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
            else if (clr_i) q_o <= 1'b0;
         end
         AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o); // R12
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q_o <= 1'b0;
            else if (clr_i) q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
         end
         AST_CLR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> !q_o); // R12
      end
   endgenerate
endmodule

// File: rtl/i2cs_field_latch.sv
module i2cs_field_latch #(
   parameter int          W         = 1,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      if (W < 1) $error("i2cs_field_latch: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= RESET_VAL;
      else if (ld_i) q_o <= d_i;
   end

   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> $stable(q_o)); // R7
endmodule

// File: rtl/i2cs_sda_gate.sv
module i2cs_sda_gate (
   input  logic coll_i,
   input  logic eng_low_i,
   output logic drive_low_o
);
   always_comb drive_low_o = eng_low_i & ~coll_i;
endmodule

// File: rtl/i2cs_status_ctrl.sv
module i2cs_status_ctrl
   import i2cs_stat_pkg::*;
#(
   parameter bit SET_PRIORITY  = 1'b1,
   parameter bit BUSERR_GATED  = 1'b1,
   parameter bit ADDR_OVER_STOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_byte_done,
   input  logic              ev_addr_match,
   input  logic              ev_stop,
   input  logic              ev_start,
   input  logic              ev_ack_valid,
   input  logic              ack_bit,
   input  logic              addr_dir,
   input  logic              ev_coll,
   input  logic              ev_illegal,
   input  logic              master_en,
   input  logic              eng_sda_low,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [STAT_W-1:0] reg_wdata,
   input  logic              data_rd,
   input  logic              data_wr,
   input  logic              cmd_wr,
   input  logic              dif_ien,
   input  logic              aif_ien,
   output logic [STAT_W-1:0] status,
   output logic              scl_hold,
   output logic              sda_drive_low,
   output logic              irq_data,
   output logic              irq_addr
);
   initial begin
      if (STAT_W != 8) $error("i2cs_status_ctrl: status byte must be 8 bits");
   end

   logic                implicit_clr;
   logic [N_STICKY-1:0] set_vec, clr_vec, flag_q;
   logic                berr_set;
   logic                ap_q, dir_q, rxack_q;
   logic                hold;
   logic                unused_ro_bits;

   assign implicit_clr   = data_rd | data_wr | cmd_wr;
   assign unused_ro_bits = ^{reg_wdata[B_HOLD], reg_wdata[B_RXACK],
                             reg_wdata[B_DIR], reg_wdata[B_AP], reg_rd};

   generate
      if (BUSERR_GATED) begin : g_berr_gated
         assign berr_set = ev_illegal & master_en;
      end else begin : g_berr_free
         assign berr_set = ev_illegal;
      end
   endgenerate

   always_comb begin
      set_vec         = '0;
      clr_vec         = '0;
      set_vec[I_DIF]  = ev_byte_done;
      set_vec[I_APIF] = ev_addr_match | ev_stop;
      set_vec[I_COLL] = ev_coll;
      set_vec[I_BERR] = berr_set;
      clr_vec[I_DIF]  = implicit_clr;
      clr_vec[I_APIF] = implicit_clr;
      clr_vec[I_COLL] = ev_start;
      for (int k = 0; k < N_STICKY; k++)
         clr_vec[k] = clr_vec[k] | (reg_wr & reg_wdata[sticky_pos(k)]);
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_STICKY; gi++) begin : g_sticky
         i2cs_flag_cell #(.SET_WINS(SET_PRIORITY)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[gi]),
            .clr_i (clr_vec[gi]),
            .q_o   (flag_q[gi])
         );
      end
   endgenerate

   logic ap_d;
   generate
      if (ADDR_OVER_STOP) begin : g_ap_addr
         assign ap_d = ev_addr_match;
      end else begin : g_ap_stop
         assign ap_d = ~ev_stop;
      end
   endgenerate

   i2cs_field_latch #(.W(1)) u_ap (
      .clk (clk), .rst_n (rst_n),
      .ld_i (ev_addr_match | ev_stop), .d_i (ap_d), .q_o (ap_q));

   i2cs_field_latch #(.W(1)) u_dir (
      .clk (clk), .rst_n (rst_n),
      .ld_i (ev_addr_match), .d_i (addr_dir), .q_o (dir_q));

   i2cs_field_latch #(.W(1)) u_rxack (
      .clk (clk), .rst_n (rst_n),
      .ld_i (ev_ack_valid), .d_i (ack_bit), .q_o (rxack_q));

   i2cs_sda_gate u_gate (
      .coll_i      (flag_q[I_COLL]),
      .eng_low_i   (eng_sda_low),
      .drive_low_o (sda_drive_low));

   assign hold = flag_q[I_DIF] | flag_q[I_APIF];

   always_comb begin
      status          = '0;
      status[B_DIF]   = flag_q[I_DIF];
      status[B_APIF]  = flag_q[I_APIF];
      status[B_HOLD]  = hold;
      status[B_RXACK] = rxack_q;
      status[B_COLL]  = flag_q[I_COLL];
      status[B_BERR]  = flag_q[I_BERR];
      status[B_DIR]   = dir_q;
      status[B_AP]    = ap_q;
   end

   assign scl_hold = hold;
   assign irq_data = flag_q[I_DIF]  & dif_ien;
   assign irq_addr = flag_q[I_APIF] & aif_ien;

   logic quiet;
   assign quiet = !(ev_byte_done || ev_addr_match || ev_stop || ev_start ||
                    ev_ack_valid || ev_coll || ev_illegal || reg_wr ||
                    data_rd || data_wr || cmd_wr);

   AST_DIF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_byte_done |=> status[B_DIF]); // R2
   AST_IMPLICIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      implicit_clr && !ev_byte_done && !ev_addr_match && !ev_stop
      |=> !status[B_DIF] && !status[B_APIF]); // R3
   AST_ADDR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_addr_match |=> status[B_APIF] && status[B_AP]); // R4
   AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop && !ev_addr_match |=> status[B_APIF] && !status[B_AP]); // R4
   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_hold) |-> $past(implicit_clr || reg_wr)); // R6
   AST_COLL_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      status[B_COLL] |-> !sda_drive_low); // R8
   AST_COLL_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start && !ev_coll |=> !status[B_COLL]); // R8
   AST_BERR_NEEDS_MEN: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en && !status[B_BERR] |=> !status[B_BERR]); // R9
   AST_DIR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_addr_match |=> status[B_DIR] == $past(addr_dir)); // R10
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !dif_ien |-> !irq_data); // R11
   AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && quiet |=> $stable(status)); // R13
endmodule

// File: tb/i2cs_status_ctrl_tb.sv
module i2cs_status_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_byte_done = 0, ev_addr_match = 0, ev_stop = 0, ev_start = 0;
   logic ev_ack_valid = 0, ack_bit = 0, addr_dir = 0, ev_coll = 0;
   logic ev_illegal = 0, master_en = 0, eng_sda_low = 0, reg_rd = 0, reg_wr = 0;
   logic [7:0] reg_wdata = 8'h00;
   logic data_rd = 0, data_wr = 0, cmd_wr = 0, dif_ien = 0, aif_ien = 0;
   logic [7:0] status;
   logic scl_hold, sda_drive_low, irq_data, irq_addr;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   i2cs_status_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ev_byte_done(ev_byte_done),
      .ev_addr_match(ev_addr_match), .ev_stop(ev_stop), .ev_start(ev_start),
      .ev_ack_valid(ev_ack_valid), .ack_bit(ack_bit), .addr_dir(addr_dir),
      .ev_coll(ev_coll), .ev_illegal(ev_illegal), .master_en(master_en),
      .eng_sda_low(eng_sda_low), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .data_rd(data_rd), .data_wr(data_wr),
      .cmd_wr(cmd_wr), .dif_ien(dif_ien), .aif_ien(aif_ien),
      .status(status), .scl_hold(scl_hold), .sda_drive_low(sda_drive_low),
      .irq_data(irq_data), .irq_addr(irq_addr));

   // behavioural reference model
   bit m_dif, m_apif, m_rxack, m_coll, m_berr, m_dir, m_ap;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_dif, m_apif, m_rxack, m_coll, m_berr, m_dir, m_ap} = '0;
      end else begin
         if (data_rd || data_wr || cmd_wr || (reg_wr && reg_wdata[7])) m_dif = 0;
         if (data_rd || data_wr || cmd_wr || (reg_wr && reg_wdata[6])) m_apif = 0;
         if (ev_start || (reg_wr && reg_wdata[3])) m_coll = 0;
         if (reg_wr && reg_wdata[2]) m_berr = 0;
         if (ev_byte_done) m_dif = 1;
         if (ev_stop) begin m_apif = 1; m_ap = 0; end
         if (ev_addr_match) begin m_apif = 1; m_ap = 1; m_dir = addr_dir; end
         if (ev_coll) m_coll = 1;
         if (ev_illegal && master_en) m_berr = 1;
         if (ev_ack_valid) m_rxack = ack_bit;
      end
   end

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic compare_model();
      bit hold;
      hold = m_dif | m_apif;
      chk("R2 data flag", status[7], m_dif);
      chk("R4 addr/stop flag", status[6], m_apif);
      chk("R6 hold bit", status[5], hold);
      chk("R7 rxack", status[4], m_rxack);
      chk("R8 collision", status[3], m_coll);
      chk("R9 bus error", status[2], m_berr);
      chk("R10 direction", status[1], m_dir);
      chk("R4 cause bit", status[0], m_ap);
      chk("R6 scl_hold", scl_hold, hold);
      chk("R8 sda gate", sda_drive_low, eng_sda_low & ~m_coll);
      chk("R11 irq_data", irq_data, m_dif & dif_ien);
      chk("R11 irq_addr", irq_addr, m_apif & aif_ien);
   endtask

   task automatic tick();
      @(negedge clk);
      compare_model();
      {ev_byte_done, ev_addr_match, ev_stop, ev_start, ev_ack_valid} = '0;
      {ev_coll, ev_illegal, reg_rd, reg_wr, data_rd, data_wr, cmd_wr} = '0;
      reg_wdata = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      dif_ien = 1; aif_ien = 1;
      repeat (3) @(negedge clk);
      chk("R1 reset status", status, 8'h00);
      chk("R1 reset outputs", {scl_hold, sda_drive_low, irq_data, irq_addr}, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 idle status", status, 8'h00);
      // address, master read
      addr_dir = 1; ev_addr_match = 1; tick();
      chk("R4 R10 address match", status, 8'h63);
      chk("R6 hold on address", scl_hold, 1);
      chk("R11 address irq", irq_addr, 1);
      data_rd = 1; tick();
      chk("R3 data read clears", status, 8'h03);
      ev_byte_done = 1; ev_ack_valid = 1; ack_bit = 1; tick();
      chk("R2 R7 byte with NACK", status, 8'hB3);
      data_wr = 1; tick();
      chk("R3 data write clears", status, 8'h13);
      reg_wr = 1; reg_wdata = 8'h33; tick();
      chk("R5 read-only bits ignore write", status, 8'h13);
      ev_stop = 1; ev_ack_valid = 1; ack_bit = 0; tick();
      chk("R4 R7 stop cause", status, 8'h62);
      reg_wr = 1; reg_wdata = 8'h40; tick();
      chk("R5 w1c address flag", status, 8'h02);
      // collision
      eng_sda_low = 1; tick();
      chk("R8 gate open", sda_drive_low, 1);
      ev_coll = 1; tick();
      chk("R8 collision set", status, 8'h0A);
      chk("R8 no drive low", sda_drive_low, 0);
      ev_byte_done = 1; tick();
      chk("R8 R2 transfer still flags", status, 8'hAA);
      cmd_wr = 1; tick();
      chk("R3 command clears", status, 8'h0A);
      ev_start = 1; tick();
      chk("R8 start clears collision", status, 8'h02);
      chk("R8 drive restored", sda_drive_low, 1);
      ev_coll = 1; tick();
      reg_wr = 1; reg_wdata = 8'h08; tick();
      chk("R5 w1c collision", status, 8'h02);
      eng_sda_low = 0;
      // bus error
      ev_illegal = 1; tick();
      chk("R9 masked without enable", status, 8'h02);
      master_en = 1; ev_illegal = 1; tick();
      chk("R9 bus error set", status, 8'h06);
      reg_wr = 1; reg_wdata = 8'h04; tick();
      chk("R5 w1c bus error", status, 8'h02);
      // same-cycle set and clear
      ev_byte_done = 1; data_rd = 1; tick();
      chk("R12 set wins", status, 8'hA2);
      dif_ien = 0; tick();
      chk("R11 data irq masked", irq_data, 0);
      reg_rd = 1; tick();
      chk("R13 read has no effect", status, 8'hA2);
      addr_dir = 0; ev_addr_match = 1; ev_stop = 1; tick();
      chk("R10 R4 master write, address wins", status, 8'hE1);
      for (int n = 0; n < 40; n++) begin
         ev_byte_done = n[0]; ev_addr_match = n[2]; ev_stop = n[3];
         addr_dir = n[1]; data_rd = (n % 5 == 0); ev_coll = (n % 7 == 3);
         ev_start = (n % 7 == 6); eng_sda_low = n[1];
         reg_wr = (n % 6 == 4); reg_wdata = 8'(n * 37);
         ev_ack_valid = n[2]; ack_bit = n[3]; ev_illegal = (n % 9 == 2);
         tick();
      end
      tick();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule